// File: doc/BRIEF.md
# Double-Buffered Timer PWM Generator

This block produces one pulse-width-modulated output from a free-running up-counter. The counter is compared against an active period value and an active compare value, and the compare result passes through a polarity stage and an enable gate before it reaches the pin. Software programs the block over a simple single-cycle register bus. Writes to the active pair take effect on the next clock. Writes to a second pair of shadow registers are held back and copied into the active pair only when the counter wraps. A waveform that is already running therefore always finishes its current period with the old settings before the new ones apply.

Counting is governed by a two-state machine. In `ST_HALT` the counter holds its value. In `ST_COUNT` it advances by one each clock and returns to zero on the clock after it reaches the active period. The transition HALT→COUNT is taken on the first clock edge at which the run bit of the control register reads as set. The transition COUNT→HALT is taken on the first edge at which it reads as clear. Each of these two states also holds itself while the run bit keeps its value.

Top module: `pwm_aux`

## Requirements
- R1: After reset, every register reads zero, `pwm_out` is low, the counter is halted at zero and no shadow load is pending.
- R2: Registers are decoded by byte address: control 0x00, active period 0x04, active compare 0x08, shadow period 0x0C, shadow compare 0x10. A read (`bus_en`=1, `bus_we`=0) returns data on `bus_rdata` in the same cycle. Any other address reads zero. The control register keeps bits 15:0 of a write and reads back with its upper bits zero.
- R3: Control bit 0 is the run bit. The counter first moves on the second clock edge after the write that sets the bit. After the write that clears it, the counter moves on one more edge and then holds its value.
- R4: While counting, the counter steps 0,1,…,P, where P is the active period, and returns to 0 on the clock after it holds P. A period therefore lasts P+1 clocks.
- R5: The uninverted waveform is high while the count is below the active compare value C. C=0 gives a constant low. C≥P gives a constant high.
- R6: Control bit 2 inverts the waveform, so that C then sets the low time instead of the high time.
- R7: Control bit 1 enables the waveform. While it is clear, `pwm_out` is low whatever the polarity bit and the count.
- R8: A write to an active register takes effect on the next clock, whether the counter runs or not. A period of 1 with a compare of 1 is accepted and gives a constant high.
- R9: A write to either shadow register sets a pending flag and leaves the active pair unchanged. On the first wrap while counting, both shadow values are copied into the active pair and the flag clears. The copy takes priority over an active-register write in the same cycle.
- R10: If a shadow write lands on the wrap clock itself, the active pair receives the shadow contents from before that write. The new value stays pending and is copied at the following wrap.
- R11: Control bits 15:3, including the sync-disable field at bits 5:4, are storage only. They read back as written and have no effect on the counter or the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| pwm_out | output | 1 | PWM waveform |

## Verification
The two functions that can share a clock are a software write to a shadow register and the period-end load of the shadow pair into the active pair. The bench provokes this by first setting a pending shadow period. It then counts idle cycles so that a shadow-compare write strobes exactly while the counter holds the period value. The result is judged from the waveform at `pwm_out`: one full period must still use the old compare value, and only the period after it must show the newly written one.

// File: rtl/pwm_aux_pkg.sv
package pwm_aux_pkg;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } tmr_state_t;

    localparam logic [7:0] ADDR_CTRL = 8'h00;
    localparam logic [7:0] ADDR_APER = 8'h04;
    localparam logic [7:0] ADDR_ACMP = 8'h08;
    localparam logic [7:0] ADDR_SPER = 8'h0C;
    localparam logic [7:0] ADDR_SCMP = 8'h10;

    localparam int CB_RUN  = 0;
    localparam int CB_WAVE = 1;
    localparam int CB_INV  = 2;

endpackage

// File: rtl/pwm_aux_regs.sv
module pwm_aux_regs
    import pwm_aux_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          wrap,
    output logic          run_o,
    output logic          wave_o,
    output logic          inv_o,
    output logic [DW-1:0] per_act,
    output logic [DW-1:0] cmp_act,
    output logic [DW-1:0] per_sh,
    output logic [DW-1:0] cmp_sh,
    output logic          pend
);

    localparam int PADW = DW - CW;

    logic [CW-1:0] ctrl_q;
    logic wr_ctrl, wr_aper, wr_acmp, wr_sper, wr_scmp, rd_en;

    assign rd_en   = bus_en && !bus_we;
    assign wr_ctrl = bus_en && bus_we && (bus_addr == AW'(ADDR_CTRL));
    assign wr_aper = bus_en && bus_we && (bus_addr == AW'(ADDR_APER));
    assign wr_acmp = bus_en && bus_we && (bus_addr == AW'(ADDR_ACMP));
    assign wr_sper = bus_en && bus_we && (bus_addr == AW'(ADDR_SPER));
    assign wr_scmp = bus_en && bus_we && (bus_addr == AW'(ADDR_SCMP));

    // control register: all bits stored, three decoded
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= bus_wdata[CW-1:0];
        end
    end

    // active pair: the period-end copy wins over a direct write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_act <= '0;
            cmp_act <= '0;
        end else if (wrap && pend) begin
            per_act <= per_sh;
            cmp_act <= cmp_sh;
        end else begin
            if (wr_aper) per_act <= bus_wdata;
            if (wr_acmp) cmp_act <= bus_wdata;
        end
    end

    // shadow pair and its pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_sh <= '0;
            cmp_sh <= '0;
            pend   <= 1'b0;
        end else begin
            if (wr_sper) per_sh <= bus_wdata;
            if (wr_scmp) cmp_sh <= bus_wdata;
            if (wr_sper || wr_scmp) begin
                pend <= 1'b1;
            end else if (wrap) begin
                pend <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                AW'(ADDR_CTRL): bus_rdata = {{PADW{1'b0}}, ctrl_q};
                AW'(ADDR_APER): bus_rdata = per_act;
                AW'(ADDR_ACMP): bus_rdata = cmp_act;
                AW'(ADDR_SPER): bus_rdata = per_sh;
                AW'(ADDR_SCMP): bus_rdata = cmp_sh;
                default:        bus_rdata = '0;
            endcase
        end
    end

    assign run_o  = ctrl_q[CB_RUN];
    assign wave_o = ctrl_q[CB_WAVE];
    assign inv_o  = ctrl_q[CB_INV];

endmodule

// File: rtl/pwm_aux_timer.sv
module pwm_aux_timer
    import pwm_aux_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] per_act,
    output logic [DW-1:0] cnt,
    output logic          wrap,
    output tmr_state_t    state
);

    tmr_state_t state_nxt;
    logic       counting;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HALT;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HALT:  if (run)  state_nxt = ST_COUNT;
            ST_COUNT: if (!run) state_nxt = ST_HALT;
        endcase
    end

    // state outputs
    always_comb begin
        counting = 1'b0;
        unique case (state)
            ST_HALT:  counting = 1'b0;
            ST_COUNT: counting = 1'b1;
        endcase
        wrap = counting && (cnt >= per_act);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (counting) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_aux_out.sv
module pwm_aux_out #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] per_act,
    input  logic [DW-1:0] cmp_act,
    input  logic          wave_en,
    input  logic          inv,
    output logic          pwm
);

    logic cmp_zero, cmp_sat, raw;

    always_comb begin
        cmp_zero = (cmp_act == '0);
        cmp_sat  = (cmp_act >= per_act);
        raw      = !cmp_zero && (cmp_sat || (cnt < cmp_act));
        pwm      = wave_en && (raw ^ inv);
    end

endmodule

// File: rtl/pwm_aux.sv
module pwm_aux
    import pwm_aux_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          pwm_out
);

    logic          run, wave_en, inv, wrap, pend;
    logic [DW-1:0] per_act, cmp_act, per_sh, cmp_sh, cnt;
    tmr_state_t    state;

    pwm_aux_regs #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wrap      (wrap),
        .run_o     (run),
        .wave_o    (wave_en),
        .inv_o     (inv),
        .per_act   (per_act),
        .cmp_act   (cmp_act),
        .per_sh    (per_sh),
        .cmp_sh    (cmp_sh),
        .pend      (pend)
    );

    pwm_aux_timer #(.DW(DW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .per_act (per_act),
        .cnt     (cnt),
        .wrap    (wrap),
        .state   (state)
    );

    pwm_aux_out #(.DW(DW)) u_out (
        .cnt     (cnt),
        .per_act (per_act),
        .cmp_act (cmp_act),
        .wave_en (wave_en),
        .inv     (inv),
        .pwm     (pwm_out)
    );

endmodule

// File: rtl/pwm_aux_chk.sv
module pwm_aux_chk
    import pwm_aux_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_en,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic          wave_en,
    input logic          pwm_out,
    input tmr_state_t    state,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] per_act,
    input logic [DW-1:0] cmp_act,
    input logic [DW-1:0] per_sh,
    input logic [DW-1:0] cmp_sh,
    input logic          pend,
    input logic          wrap
);

    logic act_wr;
    assign act_wr = bus_en && bus_we &&
                    ((bus_addr == AW'(ADDR_APER)) || (bus_addr == AW'(ADDR_ACMP)));

    assert_wave_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wave_en |-> !pwm_out);

    assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && cnt >= per_act) |=> (cnt == '0));

    assert_halt_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> $stable(cnt));

    assert_shadow_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && pend) |=> (per_act == $past(per_sh)) && (cmp_act == $past(cmp_sh)));

    assert_active_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wrap && pend) && !act_wr) |=> ($stable(per_act) && $stable(cmp_act)));

    assert_pend_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && pend && !(bus_en && bus_we)) |=> !pend);

endmodule

bind pwm_aux pwm_aux_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wave_en  (wave_en),
    .pwm_out  (pwm_out),
    .state    (state),
    .cnt      (cnt),
    .per_act  (per_act),
    .cmp_act  (cmp_act),
    .per_sh   (per_sh),
    .cmp_sh   (cmp_sh),
    .pend     (pend),
    .wrap     (wrap)
);

// File: tb/pwm_aux_bench.sv
module pwm_aux_bench;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_APER = 8'h04;
    localparam logic [7:0] A_ACMP = 8'h08;
    localparam logic [7:0] A_SPER = 8'h0C;
    localparam logic [7:0] A_SCMP = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_en, bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        pwm_out;

    typedef struct {
        bit          is_rd;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    always #5 clk = ~clk;

    pwm_aux u_pwm_aux (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // monitor: compares queued expectations 1 ns after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = it.is_rd ? bus_rdata : {31'b0, pwm_out};
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(input bit is_rd, input logic [31:0] exp, input string tag);
        item_t it;
        it.is_rd = is_rd;
        it.exp   = exp;
        it.tag   = tag;
        q.push_back(it);
    endtask

    // all driver tasks start and end at a falling edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        push(1'b1, exp, tag);
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic expect_wave(input string pat, input string tag);
        for (int i = 0; i < pat.len(); i++) begin
            push(1'b0, (pat[i] == "1") ? 32'd1 : 32'd0, $sformatf("%s idx%0d", tag, i));
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-reqs actual hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_wave("0", "R1 out");
        bus_read(A_CTRL, 32'h0, "R1 ctrl");
        bus_read(A_APER, 32'h0, "R1 aper");
        bus_read(A_ACMP, 32'h0, "R1 acmp");
        bus_read(A_SPER, 32'h0, "R1 sper");
        bus_read(A_SCMP, 32'h0, "R1 scmp");

        // R2 readback, R3 start lag, R4 period P+1, R5 compare
        bus_write(A_APER, 32'd4);
        bus_write(A_ACMP, 32'd2);
        bus_read(A_APER, 32'd4, "R2 aper readback");
        bus_read(A_ACMP, 32'd2, "R2 acmp readback");
        bus_write(A_CTRL, 32'h3);
        expect_wave("111000110001", "R3_R4_R5 run p4 c2");

        // R6 inverted polarity, counter now at 1 -> 2
        bus_write(A_CTRL, 32'h7);
        expect_wave("1110011100", "R6 inverted");

        // R7 wave disabled while running inverted
        bus_write(A_CTRL, 32'h5);
        expect_wave("00000", "R7 wave off");

        // R3 stop: one more step, then hold at 0
        bus_write(A_CTRL, 32'h2);
        expect_wave("011111", "R3 stop hold");

        // R5 compare zero, R8 direct writes and minimum period
        bus_write(A_ACMP, 32'd0);
        expect_wave("0", "R5 cmp zero");
        bus_write(A_APER, 32'd1);
        bus_write(A_ACMP, 32'd1);
        expect_wave("1", "R8 direct write");
        bus_read(A_APER, 32'd1, "R8 aper");
        bus_read(A_ACMP, 32'd1, "R8 acmp");
        bus_write(A_CTRL, 32'h3);
        expect_wave("11111111", "R8_R5 p1 c1 const high");

        // R9 shadow pair applied at period end
        bus_write(A_CTRL, 32'h2);
        bus_write(A_APER, 32'd7);
        bus_write(A_ACMP, 32'd3);
        bus_write(A_SPER, 32'd3);
        bus_write(A_SCMP, 32'd1);
        bus_read(A_APER, 32'd7, "R9 aper untouched");
        bus_read(A_ACMP, 32'd3, "R9 acmp untouched");
        bus_read(A_SPER, 32'd3, "R9 sper");
        bus_read(A_SCMP, 32'd1, "R9 scmp");
        bus_write(A_CTRL, 32'h3);
        expect_wave("11100000100010", "R9 old period then new");
        bus_read(A_APER, 32'd3, "R9 aper loaded");
        bus_read(A_ACMP, 32'd1, "R9 acmp loaded");

        // R10 shadow write on the wrap clock
        bus_write(A_SPER, 32'd5);
        idle(2);
        bus_write(A_SCMP, 32'd2);
        expect_wave("1000001100001", "R10 collision");
        bus_read(A_SCMP, 32'd2, "R10 scmp");

        // R11 storage-only bits, R2 upper bits and unmapped address
        bus_write(A_CTRL, 32'hABCD_0030);
        bus_read(A_CTRL, 32'h0000_0030, "R11_R2 ctrl readback");
        expect_wave("000", "R11 no output effect");
        bus_read(8'h20, 32'h0, "R2 unmapped");

        idle(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule